// File: doc/BRIEF.md
# Set/Clear Masked Interrupt Controller

This block collects single-cycle event strobes from five sources: two timer underflows, a time-of-day alarm, a serial shift event and an external flag pin. Each strobe sets its own sticky flag. The flag is set whether or not that source is enabled. A five-bit enable mask chooses which pending flags may raise the interrupt. The block drives an active-low interrupt line and a summary bit that reads as bit 7 of the status byte.

Software changes the mask with one command byte. Bit 7 of that byte picks the action. When bit 7 is 1, every 1 in the low bits enables that source. When bit 7 is 0, every 1 in the low bits disables that source. Mask bits whose data bit is 0 keep their value in both cases.

Reading the status byte returns the flags as they are in that cycle. All flags clear at the end of the read cycle, and the interrupt line is released. A strobe that arrives during the read cycle is not lost. It sets its flag, and the next read reports it.

Top module: `irq_ctl`

## Requirements
- R1: After reset, all flags and all mask bits are 0, `irq_n` is 1 and `rd_data` is 0x00.
- R2: A mask write with `wr_data[7]`=1 sets every mask bit whose data bit in `wr_data[4:0]` is 1. Every other mask bit keeps its value.
- R3: A mask write with `wr_data[7]`=0 clears every mask bit whose data bit in `wr_data[4:0]` is 1. Every other mask bit keeps its value.
- R4: A strobe on `src[i]` sets flag i in the following cycle, whatever the mask holds. Flag i reads on `rd_data[i]`. The bit order is: bit 0 timer A, bit 1 timer B, bit 2 time-of-day alarm, bit 3 serial, bit 4 flag pin. A flag stays set until it is read.
- R5: `rd_data[7]` is 1 exactly when some flag and its mask bit are both 1. `rd_data[6:5]` always read 0.
- R6: `irq_n` is 0 exactly when `rd_data[7]` is 1.
- R7: While `rd_en` is 1, `rd_data` shows the current flags. In the next cycle every flag that had no strobe in the read cycle is 0.
- R8: A strobe in the same cycle as a read sets its flag for the next cycle, and the next read reports it.
- R9: A mask write changes `irq_n` in the cycle after the write. Flags that were already pending take part in that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src | input | NSRC | One-cycle event strobes, one per source |
| wr_en | input | 1 | Mask command write |
| wr_data | input | 8 | Mask command: bit 7 selects set (1) or clear (0); the low bits select the sources |
| rd_en | input | 1 | Status read; clears the flags at the end of the cycle |
| rd_data | output | 8 | Status byte: summary in bit 7, flags in the low bits |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with the default of five sources. With that size the full cross product of 32 mask values and 32 flag patterns is small enough to sweep in full. The summary bit and the interrupt line are compared with their arithmetic value for every one of those pairs. Set and clear commands are checked by probing each mask bit one at a time through the summary bit. The corners are covered in the same sweeps: a read that coincides with a strobe, and a mask write made while flags are already pending.

// File: rtl/irq_ctl.sv
module irq_ctl #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic            rd_en,
  output logic [7:0]      rd_data,
  output logic            irq_n
);
  localparam int PAD = 7 - NSRC;

  logic [NSRC-1:0] flags;
  logic [NSRC-1:0] mask;
  logic            pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
    end else begin
      flags <= rd_en ? src : (flags | src);
      if (wr_en) begin
        if (wr_data[7]) mask <= mask | wr_data[NSRC-1:0];
        else            mask <= mask & ~wr_data[NSRC-1:0];
      end
    end
  end

  assign pend    = |(flags & mask);
  assign rd_data = {pend, {PAD{1'b0}}, flags};
  assign irq_n   = ~pend;
endmodule

module irq_ctl_chk #(
  parameter int NSRC = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src,
  input logic            wr_en,
  input logic [7:0]      wr_data,
  input logic            rd_en,
  input logic [7:0]      rd_data,
  input logic            irq_n,
  input logic [NSRC-1:0] flags,
  input logic [NSRC-1:0] mask
);
  a_r2_set_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7]) |=> mask == ($past(mask) | $past(wr_data[NSRC-1:0])));

  a_r3_clr_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[7]) |=> mask == ($past(mask) & ~$past(wr_data[NSRC-1:0])));

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (flags & ($past(flags) | $past(src))) == ($past(flags) | $past(src)));

  a_r6_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == !rd_data[7]);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && src == '0) |=> rd_data[NSRC-1:0] == '0);

  a_r8_keep_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_data[NSRC-1:0] == $past(src));

  a_r9_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask));
endmodule

bind irq_ctl irq_ctl_chk #(.NSRC(NSRC)) chk_i (
  .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .irq_n(irq_n), .flags(flags), .mask(mask)
);

// File: tb/irq_ctl_tb_top.sv
module irq_ctl_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [4:0] src = '0;
  logic       wr_en = 0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 0;
  logic [7:0] rd_data;
  logic       irq_n;

  int n_chk = 0;
  int n_bad = 0;
  logic [4:0] m_flags = '0;
  logic [4:0] m_mask = '0;

  always #2 clk = ~clk;

  irq_ctl #(.NSRC(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq_n(irq_n)
  );

  task automatic cyc(input logic [4:0] s, input logic we, input logic [7:0] wd, input logic re);
    src = s; wr_en = we; wr_data = wd; rd_en = re;
    @(negedge clk);
    m_flags = re ? s : (m_flags | s);
    if (we) m_mask = wd[7] ? (m_mask | wd[4:0]) : (m_mask & ~wd[4:0]);
    src = '0; wr_en = 0; rd_en = 0; wr_data = '0;
  endtask

  task automatic chk(input string r);
    logic [7:0] exp;
    exp = {|(m_flags & m_mask), 2'b00, m_flags};
    n_chk++;
    if (rd_data !== exp || irq_n !== ~exp[7]) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h irq_n=%b expected rd_data=%h irq_n=%b", r, rd_data, irq_n, exp, ~exp[7]);
    end
  endtask

  task automatic probe_mask(input string r);
    for (int b = 0; b < 5; b++) begin
      cyc(5'd0, 0, 8'h00, 1);
      cyc(5'(1 << b), 0, 8'h00, 0);
      chk(r);
    end
    cyc(5'd0, 0, 8'h00, 1);
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset state");

    cyc(5'h1f, 0, 8'h00, 0);
    chk("R4 flags latch while masked");

    // R5 R6 sweep over every mask and flag pattern
    for (int m = 0; m < 32; m++) begin
      cyc(5'd0, 1, 8'h1f, 0);
      cyc(5'd0, 1, 8'(8'h80 | m), 0);
      for (int f = 0; f < 32; f++) begin
        cyc(5'd0, 0, 8'h00, 1);
        cyc(5'(f), 0, 8'h00, 0);
        chk("R5 R6 summary sweep");
      end
    end

    // R2 set accumulates; R3 clear touches only selected bits
    cyc(5'd0, 1, 8'h1f, 0);
    cyc(5'd0, 1, 8'h85, 0);
    cyc(5'd0, 1, 8'h82, 0);
    probe_mask("R2 set mask");
    for (int c = 0; c < 32; c++) begin
      cyc(5'd0, 1, 8'h9f, 0);
      cyc(5'd0, 1, 8'(c), 0);
      probe_mask("R3 clear mask");
    end

    // R7 read returns value then clears
    cyc(5'd0, 1, 8'h9f, 0);
    cyc(5'h0a, 0, 8'h00, 0);
    chk("R7 value before read");
    cyc(5'd0, 0, 8'h00, 1);
    chk("R7 flags cleared after read");

    // R8 strobe during read is kept
    cyc(5'h03, 0, 8'h00, 0);
    cyc(5'h04, 0, 8'h00, 1);
    chk("R8 coincident strobe kept");
    cyc(5'd0, 0, 8'h00, 1);
    chk("R8 reported then cleared");

    // R9 mask write against pending flags
    cyc(5'd0, 1, 8'h1f, 0);
    cyc(5'h03, 0, 8'h00, 0);
    chk("R9 pending, masked");
    src = '0; wr_en = 1; wr_data = 8'h82; rd_en = 0;
    #1 chk("R9 no change before edge");
    @(negedge clk);
    m_mask = m_mask | 5'h02;
    wr_en = 0; wr_data = '0;
    chk("R9 irq after set write");
    cyc(5'd0, 1, 8'h02, 0);
    chk("R9 irq released after clear write");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule